// File: doc/BRIEF.md
# Single-Wire Bus Slave Slot Engine

This block is the physical layer of a slave on an open-drain single-wire bus. It watches the line through a synchronizer and controls an active-low pull-down enable for the pad. It recognises bus resets from the master and answers each one with a presence pulse. It also splits the rest of the traffic into bit slots. In a write slot it reports the bit the master sent. In a read slot it places the bit the upper layer asked to send.

Time is measured in ticks, and a tick is a programmable number of clock cycles (one microsecond at the default). There are two timing sets, one for normal speed and one for fast speed, and a select input picks between them at run time. The layer above assembles bytes. That layer offers a bit before each slot, takes the bit reported at the end of each slot, and restarts its protocol when it sees the reset event.

Top module: `sw_slot_slave`

## Requirements
- R1: After reset, `pd_n` is 1 (line released), and `rx_valid` and `reset_seen` are 0.
- R2: A slot begins when the synchronized line is seen to fall while the engine is idle. Exactly SAMPLE ticks later the engine samples the synchronized line and reports it on `rx_bit` (high = 1, low = 0) together with a `rx_valid` pulse one cycle wide.
- R3: If `tx_req` is 1 when the fall is detected and `tx_bit` is 0, the slot is a read slot. `pd_n` is then 0 for exactly SAMPLE*TICK_DIV+1 cycles, from the cycle after the fall is detected until the sampling point, and the bit reported is 0.
- R4: In a read slot with `tx_bit` = 1, `pd_n` stays 1 and the bit reported is the line level.
- R5: When the line has been low for RESET ticks, the engine drops any slot in progress and waits for the line to go high. On that rise it gives a one-cycle `reset_seen` pulse.
- R6: PRES_WAIT*TICK_DIV+1 cycles after the `reset_seen` pulse, `pd_n` goes to 0 and stays there for PRES_LOW*TICK_DIV+1 cycles.
- R7: Reset detection works in every state. A reset pulse that begins as a read-0 slot first reports bit 0, then releases the line, then gives `reset_seen` and a presence pulse.
- R8: When `overdrive` is 1, the fast timing set (OD_*) replaces the normal set (STD_*) for sampling, the presence wait, the presence length and the reset threshold.
- R9: After a slot is sampled, no new slot starts until the synchronized line has been seen high. A low level held past the sampling point gives only one `rx_valid`.
- R10: `tx_req` and `tx_bit` are read only at the detected fall. A change to them during a slot does not alter `pd_n` or the bit reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | 1 | Raw level of the bus line |
| overdrive | input | 1 | 1 selects the fast timing set |
| tx_req | input | 1 | 1 makes the next slot a read slot |
| tx_bit | input | 1 | Bit to place in the next read slot |
| pd_n | output | 1 | Active-low pull-down enable for the pad |
| rx_valid | output | 1 | One-cycle strobe at each slot's sampling point |
| rx_bit | output | 1 | Line level sampled in the last slot |
| reset_seen | output | 1 | One-cycle strobe when a bus reset ends |

## Verification
The master model drives write-1 slots, which release early, and write-0 slots, which hold low. Comparing them shows that sampling falls inside the window and not at the edge. Read slots with bit 0 and bit 1 check the length of the pull and show that a 1 leaves the line untouched. Some read slots flip `tx_req`/`tx_bit` mid-slot, which shows that these inputs are latched at the fall. Long resets that start from idle and from a read-0 slot, an over-long write 0, and the same traffic at fast speed check the reset threshold, the presence timing, the single strobe per slot, and the switch between timing sets.

// File: rtl/sw_slot_pkg.sv
package sw_slot_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SLOT,
      ST_RELEASE,
      ST_RST_HOLD,
      ST_PRES_GAP,
      ST_PRES_LOW
   } slot_state_e;

endpackage

// File: rtl/sw_sync.sv
module sw_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sw_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      chain[i] <= RST_VAL;
            else if (i == 0) chain[i] <= d;
            else             chain[i] <= chain[(i == 0) ? 0 : i-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/sw_tick_timer.sv
module sw_tick_timer #(
   parameter int DIV = 125,
   parameter int CW  = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   output logic [CW-1:0] cnt
);

   logic tick;

   generate
      if (DIV < 1) begin : g_bad_div
         $error("sw_tick_timer divider must be at least 1");
      end

      if (DIV == 1) begin : g_no_pre
         assign tick = 1'b1;
      end else begin : g_pre
         localparam int PW = $clog2(DIV);
         logic [PW-1:0] pre;
         assign tick = (pre == PW'(DIV-1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     pre <= '0;
            else if (clr)   pre <= '0;
            else if (tick)  pre <= '0;
            else            pre <= pre + 1'b1;
         end
         a_r6_pre_range: assert property (@(posedge clk) disable iff (!rst_n)
            pre <= PW'(DIV-1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (clr)               cnt <= '0;
      else if (tick && !(&cnt))   cnt <= cnt + 1'b1;
   end

   // R6: elapsed time never runs backwards unless restarted
   a_r6_count_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (cnt >= $past(cnt)));

endmodule

// File: rtl/sw_speed_sel.sv
module sw_speed_sel #(
   parameter int CW            = 10,
   parameter int STD_SAMPLE    = 30,
   parameter int STD_PRES_WAIT = 30,
   parameter int STD_PRES_LOW  = 120,
   parameter int STD_RESET     = 480,
   parameter int OD_SAMPLE     = 3,
   parameter int OD_PRES_WAIT  = 3,
   parameter int OD_PRES_LOW   = 12,
   parameter int OD_RESET      = 48
) (
   input  logic          fast,
   output logic [CW-1:0] t_sample,
   output logic [CW-1:0] t_gap,
   output logic [CW-1:0] t_pres,
   output logic [CW-1:0] t_reset
);

   always_comb begin
      if (fast) begin
         t_sample = CW'(OD_SAMPLE);
         t_gap    = CW'(OD_PRES_WAIT);
         t_pres   = CW'(OD_PRES_LOW);
         t_reset  = CW'(OD_RESET);
      end else begin
         t_sample = CW'(STD_SAMPLE);
         t_gap    = CW'(STD_PRES_WAIT);
         t_pres   = CW'(STD_PRES_LOW);
         t_reset  = CW'(STD_RESET);
      end
   end

endmodule

// File: rtl/sw_slot_slave.sv
module sw_slot_slave
   import sw_slot_pkg::*;
#(
   parameter int TICK_DIV      = 125,
   parameter int SYNC_STAGES   = 2,
   parameter int STD_SAMPLE    = 30,
   parameter int STD_PRES_WAIT = 30,
   parameter int STD_PRES_LOW  = 120,
   parameter int STD_RESET     = 480,
   parameter int OD_SAMPLE     = 3,
   parameter int OD_PRES_WAIT  = 3,
   parameter int OD_PRES_LOW   = 12,
   parameter int OD_RESET      = 48
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_in,
   input  logic overdrive,
   input  logic tx_req,
   input  logic tx_bit,
   output logic pd_n,
   output logic rx_valid,
   output logic rx_bit,
   output logic reset_seen
);

   localparam int CW = $clog2(STD_RESET + 1) + 1;

   generate
      if (STD_SAMPLE < 1 || STD_SAMPLE >= STD_RESET || STD_PRES_LOW >= STD_RESET ||
          OD_SAMPLE < 1 || OD_SAMPLE >= OD_RESET || OD_PRES_LOW >= OD_RESET ||
          OD_RESET > STD_RESET || STD_PRES_WAIT > STD_RESET || OD_PRES_WAIT > STD_RESET) begin : g_bad_timing
         $error("sw_slot_slave timing set is inconsistent");
      end
   endgenerate

   logic          line_s, line_q;
   logic          fall;
   logic [CW-1:0] slot_cnt, low_cnt;
   logic [CW-1:0] t_sample, t_gap, t_pres, t_reset;
   logic          slot_clr;
   slot_state_e   st_q, st_d;
   logic          rd_q, bit_q, take_tx;
   logic          rxv_d, rst_d;

   sw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(bus_in), .q(line_s));

   sw_speed_sel #(
      .CW(CW),
      .STD_SAMPLE(STD_SAMPLE), .STD_PRES_WAIT(STD_PRES_WAIT),
      .STD_PRES_LOW(STD_PRES_LOW), .STD_RESET(STD_RESET),
      .OD_SAMPLE(OD_SAMPLE), .OD_PRES_WAIT(OD_PRES_WAIT),
      .OD_PRES_LOW(OD_PRES_LOW), .OD_RESET(OD_RESET)
   ) u_speed (
      .fast(overdrive), .t_sample(t_sample), .t_gap(t_gap),
      .t_pres(t_pres), .t_reset(t_reset));

   // phase timer: restarted on every state change
   sw_tick_timer #(.DIV(TICK_DIV), .CW(CW)) u_slot_tmr (
      .clk(clk), .rst_n(rst_n), .clr(slot_clr), .cnt(slot_cnt));

   // low-run timer: restarted whenever the line is seen high
   sw_tick_timer #(.DIV(TICK_DIV), .CW(CW)) u_low_tmr (
      .clk(clk), .rst_n(rst_n), .clr(line_s), .cnt(low_cnt));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_q <= 1'b1;
      else        line_q <= line_s;
   end

   assign fall = line_q && !line_s;

   always_comb begin
      st_d    = st_q;
      take_tx = 1'b0;
      rxv_d   = 1'b0;
      rst_d   = 1'b0;
      if (st_q != ST_RST_HOLD && low_cnt >= t_reset) begin
         st_d = ST_RST_HOLD;
      end else begin
         unique case (st_q)
            ST_IDLE: if (fall) begin
               st_d    = ST_SLOT;
               take_tx = 1'b1;
            end
            ST_SLOT: if (slot_cnt >= t_sample) begin
               st_d  = ST_RELEASE;
               rxv_d = 1'b1;
            end
            ST_RELEASE:  if (line_s) st_d = ST_IDLE;
            ST_RST_HOLD: if (line_s) begin
               st_d  = ST_PRES_GAP;
               rst_d = 1'b1;
            end
            ST_PRES_GAP: if (slot_cnt >= t_gap)  st_d = ST_PRES_LOW;
            ST_PRES_LOW: if (slot_cnt >= t_pres) st_d = ST_RELEASE;
            default:     st_d = ST_IDLE;
         endcase
      end
   end

   assign slot_clr = (st_d != st_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         rd_q       <= 1'b0;
         bit_q      <= 1'b1;
         rx_valid   <= 1'b0;
         rx_bit     <= 1'b0;
         reset_seen <= 1'b0;
      end else begin
         st_q       <= st_d;
         rx_valid   <= rxv_d;
         reset_seen <= rst_d;
         if (take_tx) begin
            rd_q  <= tx_req;
            bit_q <= tx_bit;
         end
         if (rxv_d) rx_bit <= line_s;
      end
   end

   assign pd_n = !((st_q == ST_PRES_LOW) || (st_q == ST_SLOT && rd_q && !bit_q));

   // R2: the bit strobe lasts a single cycle
   a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   // R3: the pull is already gone when the bit is reported
   a_r3_release_at_sample: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> pd_n);

   // R5: the reset event lasts a single cycle
   a_r5_single_event: assert property (@(posedge clk) disable iff (!rst_n)
      reset_seen |=> !reset_seen);

   // R6: the line stays released while the presence wait starts
   a_r6_gap_released: assert property (@(posedge clk) disable iff (!rst_n)
      reset_seen |-> pd_n);

   // R9: a reported bit is never followed at once by a fresh slot pull
   a_r9_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> pd_n);

endmodule

// File: tb/tb_sw_slot_slave.sv
module tb_sw_slot_slave;

   localparam int DIV = 4;
   localparam int S_SMP = 30, S_GAP = 30, S_PRL = 120, S_RST = 480;
   localparam int F_SMP = 3,  F_GAP = 3,  F_PRL = 12,  F_RST = 48;

   localparam int M_IDLE = 0, M_SLOT = 1, M_REL = 2, M_RSTW = 3, M_GAP = 4, M_PRL = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_low = 1'b0;
   logic overdrive = 1'b0;
   logic tx_req = 1'b0;
   logic tx_bit = 1'b1;
   logic pd_n, rx_valid, rx_bit, reset_seen;
   logic bus;

   assign bus = !m_low && (pd_n !== 1'b0);

   always #4 clk = ~clk;

   sw_slot_slave #(.TICK_DIV(DIV)) dut (
      .clk(clk), .rst_n(rst_n), .bus_in(bus), .overdrive(overdrive),
      .tx_req(tx_req), .tx_bit(tx_bit), .pd_n(pd_n), .rx_valid(rx_valid),
      .rx_bit(rx_bit), .reset_seen(reset_seen));

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // behavioural reference: line history and cycle counts
   logic sh[$];
   int   m_st, m_since, m_lowrun;
   bit   m_rd, m_bt, m_rxv, m_rxb, m_rs, m_pd;
   int   cyc = 0;

   // directed monitors
   int   run = 0;
   int   runq[$];
   bit   rxq[$];
   int   gapq[$];
   int   rs_cnt = 0;
   int   rs_cyc = 0;
   bit   rs_arm = 0;

   always @(negedge clk) begin
      cyc++;
      if (!rst_n) begin
         sh = '{1'b1, 1'b1, 1'b1};
         m_st = M_IDLE; m_since = 0; m_lowrun = 0;
         m_rd = 0; m_bt = 1; m_rxv = 0; m_rxb = 0; m_rs = 0; m_pd = 1;
      end else if (!done) begin
         int smp, gap, prl, rstt, nst;
         bit s, sq, fall, nrxv, nrs;
         chk(pd_n === m_pd, "R6", "pd_n", int'(pd_n), int'(m_pd));
         chk(rx_valid === m_rxv, "R2", "rx_valid", int'(rx_valid), int'(m_rxv));
         if (m_rxv) chk(rx_bit === m_rxb, "R2", "rx_bit", int'(rx_bit), int'(m_rxb));
         chk(reset_seen === m_rs, "R5", "reset_seen", int'(reset_seen), int'(m_rs));

         if (pd_n === 1'b0) run++;
         else if (run > 0) begin runq.push_back(run); run = 0; end
         if (reset_seen === 1'b1) begin rs_cnt++; rs_cyc = cyc; rs_arm = 1; end
         if (pd_n === 1'b0 && run == 1 && rs_arm) begin gapq.push_back(cyc - rs_cyc); rs_arm = 0; end
         if (rx_valid === 1'b1) rxq.push_back(rx_bit);

         smp  = overdrive ? F_SMP : S_SMP;
         gap  = overdrive ? F_GAP : S_GAP;
         prl  = overdrive ? F_PRL : S_PRL;
         rstt = overdrive ? F_RST : S_RST;
         s  = sh[1];
         sq = sh[2];
         fall = sq && !s;
         nst = m_st; nrxv = 0; nrs = 0;
         if (m_st != M_RSTW && m_lowrun >= rstt*DIV) nst = M_RSTW;
         else if (m_st == M_IDLE && fall) begin nst = M_SLOT; m_rd = tx_req; m_bt = tx_bit; end
         else if (m_st == M_SLOT && m_since >= smp*DIV) begin nst = M_REL; nrxv = 1; m_rxb = s; end
         else if (m_st == M_REL && s) nst = M_IDLE;
         else if (m_st == M_RSTW && s) begin nst = M_GAP; nrs = 1; end
         else if (m_st == M_GAP && m_since >= gap*DIV) nst = M_PRL;
         else if (m_st == M_PRL && m_since >= prl*DIV) nst = M_REL;
         m_since  = (nst != m_st) ? 0 : m_since + 1;
         m_lowrun = s ? 0 : m_lowrun + 1;
         m_st = nst; m_rxv = nrxv; m_rs = nrs;
         m_pd = !(nst == M_PRL || (nst == M_SLOT && m_rd && !m_bt));
         void'(sh.pop_back());
         sh.push_front(bus);
      end
   end

   task automatic seg(input logic lo, input int t);
      @(posedge clk); #1;
      m_low = lo;
      repeat (t*DIV - 1) @(posedge clk);
   endtask

   task automatic wr1();
      if (overdrive) begin seg(1, 1); seg(0, 9); end
      else begin seg(1, 6); seg(0, 74); end
   endtask

   task automatic wr0();
      if (overdrive) begin seg(1, 8); seg(0, 4); end
      else begin seg(1, 65); seg(0, 10); end
   endtask

   task automatic rd(input bit b, input bit flip);
      @(posedge clk); #1;
      tx_req = 1; tx_bit = b;
      if (overdrive) seg(1, 1); else seg(1, 2);
      if (flip) begin tx_req = 0; tx_bit = !b; end
      if (overdrive) seg(0, 9); else seg(0, 78);
      tx_req = 0; tx_bit = 1;
   endtask

   task automatic bus_reset();
      if (overdrive) begin seg(1, 60); seg(0, 80); end
      else begin seg(1, 500); seg(0, 600); end
   endtask

   task automatic clear_mon();
      rxq.delete(); runq.delete(); gapq.delete(); rs_cnt = 0;
   endtask

   task automatic expect_rx(input int n, input logic [7:0] bits, input string req);
      chk(rxq.size() == n, req, "bit count", rxq.size(), n);
      for (int i = 0; i < n && i < rxq.size(); i++)
         chk(rxq[i] == bits[i], req, "bit value", int'(rxq[i]), int'(bits[i]));
   endtask

   task automatic expect_runs(input int n, input int r0, input int r1, input string req);
      chk(runq.size() == n, req, "pull count", runq.size(), n);
      if (n > 0 && runq.size() > 0) chk(runq[0] == r0, req, "pull length", runq[0], r0);
      if (n > 1 && runq.size() > 1) chk(runq[1] == r1, req, "pull length", runq[1], r1);
   endtask

   task automatic finish_run();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (5) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      // R1: idle state after reset
      chk(pd_n === 1'b1, "R1", "pd_n", int'(pd_n), 1);
      chk(rx_valid === 1'b0, "R1", "rx_valid", int'(rx_valid), 0);
      chk(reset_seen === 1'b0, "R1", "reset_seen", int'(reset_seen), 0);

      // R5 R6: bus reset at normal speed
      clear_mon();
      bus_reset();
      chk(rs_cnt == 1, "R5", "reset events", rs_cnt, 1);
      expect_rx(1, 8'b0, "R7");
      expect_runs(1, S_PRL*DIV+1, 0, "R6");
      chk(gapq.size() == 1 && gapq[0] == S_GAP*DIV+1, "R6", "presence wait",
          (gapq.size() > 0) ? gapq[0] : -1, S_GAP*DIV+1);

      // R2: write pattern 1,0,1,1,0
      clear_mon();
      wr1(); wr0(); wr1(); wr1(); wr0();
      expect_rx(5, 8'b01101, "R2");
      expect_runs(0, 0, 0, "R2");

      // R3 / R4: read slots
      clear_mon();
      rd(0, 0);
      expect_rx(1, 8'b0, "R3");
      expect_runs(1, S_SMP*DIV+1, 0, "R3");
      clear_mon();
      rd(1, 0);
      expect_rx(1, 8'b1, "R4");
      expect_runs(0, 0, 0, "R4");

      // R10: inputs flipped mid-slot
      clear_mon();
      rd(0, 1);
      expect_rx(1, 8'b0, "R10");
      expect_runs(1, S_SMP*DIV+1, 0, "R10");
      clear_mon();
      rd(1, 1);
      expect_rx(1, 8'b1, "R10");
      expect_runs(0, 0, 0, "R10");

      // R9: low held far past the sampling point
      clear_mon();
      seg(1, 200); seg(0, 10);
      expect_rx(1, 8'b0, "R9");
      chk(rs_cnt == 0, "R9", "reset events", rs_cnt, 0);

      // R7: reset that begins as a read-0 slot
      clear_mon();
      @(posedge clk); #1 tx_req = 1; tx_bit = 0;
      seg(1, 500);
      tx_req = 0; tx_bit = 1;
      seg(0, 600);
      expect_rx(1, 8'b0, "R7");
      chk(rs_cnt == 1, "R7", "reset events", rs_cnt, 1);
      expect_runs(2, S_SMP*DIV+1, S_PRL*DIV+1, "R7");

      // R8: fast timing set
      @(posedge clk); #1 overdrive = 1;
      clear_mon();
      bus_reset();
      chk(rs_cnt == 1, "R8", "reset events", rs_cnt, 1);
      expect_runs(1, F_PRL*DIV+1, 0, "R8");
      chk(gapq.size() == 1 && gapq[0] == F_GAP*DIV+1, "R8", "presence wait",
          (gapq.size() > 0) ? gapq[0] : -1, F_GAP*DIV+1);
      clear_mon();
      wr1(); wr0(); wr0(); wr1();
      expect_rx(4, 8'b1001, "R8");
      clear_mon();
      rd(0, 0); rd(1, 0);
      expect_rx(2, 8'b10, "R8");
      expect_runs(1, F_SMP*DIV+1, 0, "R8");

      repeat (20) @(posedge clk);
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
      finish_run();
   end

endmodule